// File: doc/BRIEF.md
# Five-Channel Timer Tick Generator

This block turns one reference clock into five count-enable strobes for a five-channel down-counting timer. Two shared 8-bit prescalers divide the reference clock by (value + 1). Channels 0 and 1 take the first prescaler, and channels 2, 3 and 4 take the second. Each channel then applies its own power-of-two divider to the prescaler output. Each strobe is a single-cycle enable in the reference clock domain. No derived clocks are produced, so reprogramming needs no clock-switching care.

Software sets the block through two write-only configuration words on a small write port. Address 0 holds both prescaler values. Address 1 holds one 4-bit divider select per channel. Any configuration write restarts every prescaler and divider counter. The new setting therefore applies from the very next cycle, with a phase that software can predict.

Top module: `timer_tick_gen`

## Requirements
- R1: After reset, both prescalers are 1 and every divider select is 0, so every channel ticks every 2 cycles; the first tick comes in the second cycle after reset is released. No tick is issued while reset is asserted.
- R2: A write to address 0 sets prescaler A from `wr_data[7:0]` and prescaler B from `wr_data[15:8]`; bits above 15 are ignored.
- R3: Channels 0 and 1 are timed by prescaler A, and channels 2 to 4 by prescaler B. Two channels with equal prescaler values and equal effective dividers tick in the same cycles, whichever group they belong to.
- R4: A write to address 1 sets the divider select of channel x from `wr_data[4x+3:4x]`; bits above 19 are ignored.
- R5: A channel with prescaler value p and divider select s ticks once every (p+1)·2^s reference cycles. In the same group, a tick on a channel with a larger divider coincides with a tick on every channel with a smaller divider.
- R6: A divider select above 4 acts as 4 (divide by 16).
- R7: Each tick is a one-cycle pulse. With p > 0, a tick is never followed by another tick of the same channel in the next cycle. With p = 0 and s = 0, the channel ticks on every cycle.
- R8: Any configuration write clears all prescaler and divider counters. Counting the first cycle after the write edge as cycle 0, the first tick of a channel with period N comes in cycle N-1, so there is no tick in cycle 0 unless N = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 1 | Configuration word select: 0 prescalers, 1 divider selects |
| wr_data | input | 32 | Configuration write data |
| tick | output | 5 | Per-channel single-cycle count enable |

## Verification
On every cycle the assertions check the relations between channels. Within a group, ticks nest by divider size. Across groups, channels with equal settings tick together. A tick with a nonzero prescaler is never followed by another tick in the next cycle, and no tick comes right after a write. The exact tick period, the clamping of oversized selects, the field placement in the write data and the restart phase after a write cannot be seen from these relations. Only the bench's cycle-exact reference model shows them, by comparing every strobe in every cycle across a sequence of configurations.

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int NCH     = 5,
  parameter int PW      = 8,
  parameter int SW      = 4,
  parameter int MAX_SEL = 4,
  parameter int GRP0_CH = 2,
  parameter int DW      = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] tick
);
  localparam int NGRP     = 2;
  localparam int PRE_BITS = NGRP * PW;
  localparam int SEL_BITS = NCH * SW;
  localparam int DCW      = MAX_SEL;
  localparam logic [PRE_BITS-1:0] RST_PRE = {NGRP{PW'(1)}};

  logic [PRE_BITS-1:0] cfg_pre;
  logic [SEL_BITS-1:0] cfg_sel;
  logic [NGRP-1:0]     pre_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_pre <= RST_PRE;
      cfg_sel <= '0;
    end else if (wr_en) begin
      if (!wr_addr) cfg_pre <= wr_data[PRE_BITS-1:0];
      else          cfg_sel <= wr_data[SEL_BITS-1:0];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_pre
    logic [PW-1:0] pcnt;
    assign pre_tick[g] = (pcnt == cfg_pre[g*PW +: PW]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pcnt <= '0;
      else if (wr_en || pre_tick[g]) pcnt <= '0;
      else                         pcnt <= pcnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int G = (c < GRP0_CH) ? 0 : 1;
    logic [SW-1:0]  sel, eff;
    logic [DCW-1:0] dcnt, mask;
    assign sel  = cfg_sel[c*SW +: SW];
    assign eff  = (sel > SW'(MAX_SEL)) ? SW'(MAX_SEL) : sel;
    assign mask = ~({DCW{1'b1}} << eff);
    assign tick[c] = pre_tick[G] && ((dcnt & mask) == mask);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           dcnt <= '0;
      else if (wr_en)       dcnt <= '0;
      else if (pre_tick[G]) dcnt <= dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/timer_tick_gen_chk.sv
module timer_tick_gen_chk #(
  parameter int NCH     = 5,
  parameter int PW      = 8,
  parameter int SW      = 4,
  parameter int MAX_SEL = 4,
  parameter int GRP0_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2*PW-1:0]   cfg_pre,
  input logic [NCH*SW-1:0] cfg_sel,
  input logic [NCH-1:0]    tick
);
  function automatic int eff_sel(input logic [NCH*SW-1:0] s, input int c);
    int v;
    v = int'(s[c*SW +: SW]);
    return (v > MAX_SEL) ? MAX_SEL : v;
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_i
    localparam int GI = (i < GRP0_CH) ? 0 : 1;

    assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && !wr_en && cfg_pre[GI*PW +: PW] != '0) |=> !tick[i]);

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cfg_pre[GI*PW +: PW] == '0 || !tick[i]));

    for (genvar j = 0; j < NCH; j++) begin : g_j
      localparam int GJ = (j < GRP0_CH) ? 0 : 1;
      if (i != j && GI == GJ) begin : g_same
        assert_nest_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (tick[i] && eff_sel(cfg_sel, i) >= eff_sel(cfg_sel, j)) |-> tick[j]);
      end else if (i != j) begin : g_cross
        assert_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
          (cfg_pre[GI*PW +: PW] == cfg_pre[GJ*PW +: PW] &&
           eff_sel(cfg_sel, i) == eff_sel(cfg_sel, j)) |-> (tick[i] == tick[j]));
      end
    end
  end
endmodule

bind timer_tick_gen timer_tick_gen_chk #(
  .NCH(NCH), .PW(PW), .SW(SW), .MAX_SEL(MAX_SEL), .GRP0_CH(GRP0_CH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .cfg_pre(cfg_pre), .cfg_sel(cfg_sel), .tick(tick)
);

// File: tb/tb_timer_tick_gen.sv
module tb_timer_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic           wr_addr = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] tick;

  timer_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit started = 0;
  bit done = 0;

  int m_pre[2];
  int m_sel[NCH];
  int k = 0;

  function automatic int period(input int c);
    int s;
    s = (m_sel[c] > 4) ? 4 : m_sel[c];
    return (m_pre[(c < 2) ? 0 : 1] + 1) * (1 << s);
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_pre[0] = 1; m_pre[1] = 1;
      for (int c = 0; c < NCH; c++) m_sel[c] = 0;
      k = 0;
    end else if (wr_en) begin
      if (!wr_addr) begin
        m_pre[0] = int'(wr_data[7:0]);
        m_pre[1] = int'(wr_data[15:8]);
      end else begin
        for (int c = 0; c < NCH; c++) m_sel[c] = int'(wr_data[4*c +: 4]);
      end
      k = 0;
    end else begin
      k++;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      for (int c = 0; c < NCH; c++) begin
        logic exp;
        exp = (((k + 1) % period(c)) == 0);
        checks++;
        if (tick[c] !== exp) begin
          fails++;
          $display("FAIL %s ch%0d cycle %0d: tick=%b expected %b", cur_req, c, k, tick[c], exp);
        end
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    run(4);
    checks++;
    if (tick !== '0) begin
      fails++;
      $display("FAIL R1 tick during reset: %b expected 00000", tick);
    end
    rst_n = 1'b1;
    run(40);

    cur_req = "R2";
    wr(1'b0, 32'h0000_0302);
    run(200);

    cur_req = "R4";
    wr(1'b1, 32'h0004_3021);
    run(400);

    cur_req = "R6";
    wr(1'b1, 32'h0009_F5C7);
    run(300);

    cur_req = "R7";
    wr(1'b0, 32'hABCD_0400);
    wr(1'b1, 32'hFFF0_0000);
    run(60);
    wr(1'b1, 32'h0000_3210);
    run(200);

    cur_req = "R8";
    for (int n = 0; n < 6; n++) begin
      wr(n[0], (n[0]) ? 32'h0001_2012 : 32'h0000_0503);
      run(7 + n);
    end

    cur_req = "R3";
    wr(1'b0, 32'h0000_0505);
    wr(1'b1, 32'h0001_0210);
    run(300);

    cur_req = "R5";
    wr(1'b0, 32'h0000_FF06);
    wr(1'b1, 32'h0004_4444);
    run(9000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    done = 1'b1;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule